// File: doc/BRIEF.md
# Fractional Clock Prescaler

This block sits between a free-running system clock and a serial baud generator. It produces a one-cycle enable pulse, `tick_o`, whose average rate is the system clock rate divided by a fixed-point ratio M + N/8. M is a 5-bit integer part and N a 3-bit fraction in eighths, so the ratio runs from 1.0 to 31.875 in steps of 0.125. Fractional ratios are built with a phase accumulator. The pulse spacing alternates between the two whole cycle counts on either side of the ratio, and every run of eight pulses spans exactly 8·M + N input cycles.

Software reaches three byte-wide registers through a small write port. The ratio register holds M in bits [7:3] and N in bits [2:0]. The feature register holds an unlock bit in bit 4. The control register holds the prescaler enable in bit 7. While the enable is clear the block is in state `ST_BYPASS`, and the pulse fires on every cycle, which is a ratio of exactly 1. The enable can only be changed while the unlock bit is set. A write to the control register with the unlock bit set to 1 and data bit 7 set to 1 is transition `T_ENABLE`, which moves the block from `ST_BYPASS` to `ST_RUN`. The same write with data bit 7 set to 0 is transition `T_DISABLE`, which moves it from `ST_RUN` back to `ST_BYPASS`. Any other write leaves the state where it is.

Top module: `fracpre_top`

## Requirements
- R1: After reset the block is in ST_BYPASS, and tick_o is 1 after every clock edge, starting with the first edge after reset is released.
- R2: In ST_RUN the ratio is M + N/8, where M = ratio[7:3] and N = ratio[2:0]. Counting from a clear of the phase, the 8th pulse arrives exactly 8·M + N edges later.
- R3: In ST_BYPASS, tick_o is 1 after every edge, whatever the ratio register holds.
- R4: In ST_RUN with a target T = 8·M + N, and n counted from the last phase clear, tick_o is 1 after edge n exactly when floor(8n/T) > floor(8(n-1)/T). Consecutive pulses are therefore floor(T/8) or ceil(T/8) cycles apart.
- R5: An integer field of M = 0 behaves exactly as M = 1, so the pulse never stops.
- R6: A control-register write changes the state only if the unlock bit (feature bit 4) is already 1 before that write. Otherwise the state is unchanged.
- R7: In ST_RUN, a write to the ratio register clears the phase. tick_o is 0 after that edge, and the new ratio counts from the next edge as n = 1.
- R8: wr_sel selects the register: 0 selects control (enable in bit 7), 1 selects ratio, 2 selects feature (unlock in bit 4). A write with wr_sel = 3 has no effect.
- R9: The ratio register resets to 0x20, so enabling without writing the ratio gives a pulse on every 4th edge.
- R10: On T_ENABLE the phase starts from zero. The edge that performs the write still yields tick_o = 1, and pulse counting starts at n = 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_sel | input | 2 | Register select: 0 control, 1 ratio, 2 feature, 3 none |
| wr_data | input | 8 | Write data |
| tick_o | output | 1 | Divided-rate enable pulse, registered |

## Verification
The only output is tick_o, so every internal fault shows up as a pulse that is missing, extra or moved. A wrong state register turns pulses on every cycle into gaps, or the reverse, on the edge after the write that should or should not have changed it. A wrong accumulator value or wrong target shifts the pulse train within one period of the ratio, at most 32 cycles, and the error repeats with the 8-pulse pattern. The bench therefore compares tick_o against an independent arithmetic model on every cycle.

// File: rtl/fracpre_pkg.sv
package fracpre_pkg;

    localparam int DATA_W     = 8;
    localparam int INT_W      = 5;
    localparam int FRAC_W     = 3;
    localparam int SEL_W      = 2;
    localparam int EN_BIT     = 7;
    localparam int UNLOCK_BIT = 4;
    localparam logic [DATA_W-1:0] RATIO_RST = 8'h20;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_RATIO = 2'd1,
        SEL_FEAT  = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    typedef enum logic {
        ST_BYPASS = 1'b0,
        ST_RUN    = 1'b1
    } mode_e;

endpackage

// File: rtl/fracpre_regs.sv
module fracpre_regs
    import fracpre_pkg::*;
#(
    parameter int                DW        = DATA_W,
    parameter int                SW        = SEL_W,
    parameter int                UB        = UNLOCK_BIT,
    parameter logic [DW-1:0]     RST_RATIO = RATIO_RST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ratio_o,
    output logic          unlock_o,
    output logic          ratio_wr_o
);

    logic [DW-1:0] ratio_q;
    logic          unlock_q;
    logic          feat_wr;

    always_comb begin
        ratio_wr_o = wr_en && (wr_sel == SEL_RATIO);
        feat_wr    = wr_en && (wr_sel == SEL_FEAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q  <= RST_RATIO;
            unlock_q <= 1'b0;
        end else begin
            if (ratio_wr_o) ratio_q  <= wr_data;
            if (feat_wr)    unlock_q <= wr_data[UB];
        end
    end

    assign ratio_o  = ratio_q;
    assign unlock_o = unlock_q;

    // R8: a ratio write lands in the register on the next edge
    p_ratio_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RATIO) |=> (ratio_o == $past(wr_data)));

    // R8: select value 3 touches nothing
    p_none_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(ratio_o) && $stable(unlock_o)));

endmodule

// File: rtl/fracpre_target.sv
module fracpre_target
    import fracpre_pkg::*;
#(
    parameter int IW = INT_W,
    parameter int FW = FRAC_W,
    localparam int AW = IW + FW
) (
    input  logic [AW-1:0] ratio_i,
    output logic [AW-1:0] target_o
);

    logic [IW-1:0] int_part;
    logic [FW-1:0] frac_part;
    logic [IW-1:0] int_eff;

    always_comb begin
        int_part  = ratio_i[AW-1:FW];
        frac_part = ratio_i[FW-1:0];
        // R5: zero integer part is promoted to one
        int_eff   = (int_part == '0) ? IW'(1) : int_part;
        target_o  = {int_eff, frac_part};
    end

endmodule

// File: rtl/fracpre_accum.sv
module fracpre_accum
    import fracpre_pkg::*;
#(
    parameter int FW = FRAC_W,
    parameter int AW = INT_W + FRAC_W,
    localparam int SUMW = AW + 1,
    localparam logic [SUMW-1:0] STEP = SUMW'(1) << FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          clear_i,
    input  logic [AW-1:0] target_i,
    output logic          tick_o
);

    logic [AW-1:0]   acc_q;
    logic            tick_q;
    logic [SUMW-1:0] sum;
    logic [SUMW-1:0] tgt_ext;
    logic            wrap;
    logic [SUMW-1:0] rem;

    always_comb begin
        tgt_ext = {1'b0, target_i};
        sum     = {1'b0, acc_q} + STEP;
        wrap    = (sum >= tgt_ext);
        rem     = sum - tgt_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (!run_i) begin
            acc_q  <= '0;
            tick_q <= 1'b1;
        end else if (clear_i) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (wrap) begin
            acc_q  <= rem[AW-1:0];
            tick_q <= 1'b1;
        end else begin
            acc_q  <= sum[AW-1:0];
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R3: bypass yields a pulse on the following cycle
    p_bypass_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> tick_o);

    // R7: ratio write while running drops the pulse and zeroes the phase
    p_clear_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && clear_i) |=> (!tick_o && acc_q == '0));

    // R2: phase always stays below the target while running
    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (acc_q < target_i));

    // R4: ratios of two or more never pulse on adjacent cycles
    p_no_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_q && !clear_i && target_i >= AW'(2*STEP)) |=> !tick_o);

endmodule

// File: rtl/fracpre_top.sv
module fracpre_top
    import fracpre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick_o
);

    localparam int AW = INT_W + FRAC_W;

    mode_e             state_q;
    mode_e             state_d;
    logic [DATA_W-1:0] ratio;
    logic              unlock;
    logic              ratio_wr;
    logic [AW-1:0]     target;
    logic              run;
    logic              ctrl_wr_ok;

    fracpre_regs #(
        .DW        (DATA_W),
        .SW        (SEL_W),
        .UB        (UNLOCK_BIT),
        .RST_RATIO (RATIO_RST)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ratio_o    (ratio),
        .unlock_o   (unlock),
        .ratio_wr_o (ratio_wr)
    );

    fracpre_target #(
        .IW (INT_W),
        .FW (FRAC_W)
    ) target_i (
        .ratio_i  (ratio[AW-1:0]),
        .target_o (target)
    );

    // Next state: T_ENABLE / T_DISABLE only through an unlocked control write
    always_comb begin
        ctrl_wr_ok = wr_en && (wr_sel == SEL_CTRL) && unlock;
        state_d    = state_q;
        if (ctrl_wr_ok) begin
            state_d = wr_data[EN_BIT] ? ST_RUN : ST_BYPASS;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state_q)
            ST_BYPASS: run = 1'b0;
            ST_RUN:    run = 1'b1;
            default:   run = 1'b0;
        endcase
    end

    fracpre_accum #(
        .FW (FRAC_W),
        .AW (AW)
    ) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .clear_i  (ratio_wr),
        .target_i (target),
        .tick_o   (tick_o)
    );

    // R6: a locked control write leaves the mode alone
    p_locked_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && !unlock) |=> $stable(state_q));

    // R10: enabling from bypass still pulses on the enabling edge
    p_enable_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS && state_d == ST_RUN) |=> tick_o);

endmodule

// File: tb/fracpre_top_tb_top.sv
module fracpre_top_tb_top;

    logic       clk;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       tick_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // independent model state
    bit       m_run;
    bit       m_unlock;
    bit [7:0] m_ratio;
    int       m_n;
    bit       m_exp;

    fracpre_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tick_o  (tick_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int tgt(input bit [7:0] r);
        int m;
        m = int'(r[7:3]);
        if (m == 0) m = 1;
        return 8 * m + int'(r[2:0]);
    endfunction

    function automatic bit pulse_at(input int n, input int t);
        return ((8 * n) / t) != ((8 * (n - 1)) / t);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit w, input bit [1:0] s, input bit [7:0] d, input string tag);
        wr_en   = w;
        wr_sel  = s;
        wr_data = d;
        @(posedge clk);
        if (!m_run) begin
            m_exp = 1'b1;
            m_n   = 0;
        end else if (w && s == 2'd1) begin
            m_exp = 1'b0;
            m_n   = 0;
        end else begin
            m_n   = m_n + 1;
            m_exp = pulse_at(m_n, tgt(m_ratio));
        end
        if (w && s == 2'd0 && m_unlock) m_run    = d[7];
        if (w && s == 2'd1)             m_ratio  = d;
        if (w && s == 2'd2)             m_unlock = d[4];
        @(negedge clk);
        check(tick_o == m_exp, tag, int'(tick_o), int'(m_exp));
        wr_en = 1'b0;
    endtask

    task automatic idle(input int k, input string tag);
        for (int i = 0; i < k; i++) step(1'b0, 2'd0, 8'h00, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // R2: span of eight pulses after a ratio write
    task automatic span_check(input bit [7:0] r);
        int edges;
        int ticks;
        step(1'b1, 2'd1, r, "R7");
        edges = 0;
        ticks = 0;
        while (ticks < 8 && edges < 400) begin
            step(1'b0, 2'd0, 8'h00, "R2");
            edges++;
            if (tick_o) ticks++;
        end
        check(edges == tgt(r), "R2 span", edges, tgt(r));
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        wr_en = 0; wr_sel = 0; wr_data = 0;
        m_run = 0; m_unlock = 0; m_ratio = 8'h20; m_n = 0; m_exp = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        idle(4, "R1");
        // locked enable attempt
        step(1'b1, 2'd0, 8'h80, "R6");
        idle(4, "R6");
        // select 3 write, bypass unaffected by ratio contents
        step(1'b1, 2'd3, 8'hFF, "R8");
        idle(3, "R8");
        step(1'b1, 2'd2, 8'h10, "R8");
        step(1'b1, 2'd0, 8'h80, "R10");
        idle(13, "R9");
        // fractional ratio 3.375
        span_check(8'h1B);
        idle(10, "R4");
        // M = 0 behaves as M = 1 (target 13)
        span_check(8'h05);
        idle(30, "R5");
        // ratio 1.0 pulses every cycle while running
        step(1'b1, 2'd1, 8'h08, "R7");
        idle(5, "R2");
        // maximum ratio 31.875
        span_check(8'hFF);
        // relock then try to disable
        step(1'b1, 2'd1, 8'h20, "R7");
        step(1'b1, 2'd2, 8'h00, "R6");
        step(1'b1, 2'd0, 8'h00, "R6");
        idle(9, "R6");
        // unlocked disable -> bypass
        step(1'b1, 2'd2, 8'h10, "R3");
        step(1'b1, 2'd0, 8'h00, "R3");
        idle(6, "R3");
        step(1'b1, 2'd1, 8'h3A, "R3");
        idle(3, "R3");

        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                bit [1:0] s;
                bit [7:0] d;
                s = 2'($urandom_range(0, 3));
                d = 8'($urandom_range(0, 255));
                step(1'b1, s, d, "R4");
            end else begin
                step(1'b0, 2'd0, 8'h00, "R4");
            end
        end
        finish_run();
    end

endmodule